// File: doc/BRIEF.md
# Fault-Injectable SEC-DED Register

This block is a single protected storage word for reliability studies. A 16-bit value is held together with Hamming check bits and one overall parity bit, so a read can correct any one flipped bit and flag any two flipped bits. Beside the normal write and read ports there is an upset port: a strobe, an enable and a bit index. Each accepted strobe edge inverts one stored codeword bit without passing through the encoder, so the check bits are never regenerated for it. The damage therefore shows up only when the word is next read, as it would after a real particle strike.

The upset strobe is its own edge and is not tied to the functional clock, so a fault can land at any moment between accesses. Several faults may pile up before a read, and a read never repairs the storage. Only a normal write puts a freshly encoded word back. A parameter selects a cheaper variant: one parity bit per word that detects an odd number of flips but corrects nothing.

Top module: `seu_edac_reg`

## Requirements
- R1: A read requested with `rd_en` at a clock edge yields `rd_valid` high for exactly the following cycle, with `rd_data` equal to the last written value and both error flags low when no flips are pending.
- R2: After one accepted flip of any codeword bit k (0 to 21), a read returns the uncorrupted data and pulses `err_corrected` with `err_uncorrectable` low. Bit k is Hamming position k+1 for k up to 20, the powers of two among those positions hold check bits, the data bits fill the other positions in ascending order, and bit 21 is the overall parity.
- R3: After two accepted flips of distinct bits, a read pulses `err_uncorrectable` with `err_corrected` low.
- R4: A read does not write corrected data back. A second read of a word with one flip reports `err_corrected` again.
- R5: A normal write re-encodes the whole codeword and discards every flip accepted before it.
- R6: Two accepted flips of the same bit cancel, and a later read reports no error.
- R7: A flip whose strobe edge arrives while `wr_en` is high is discarded, so the write takes priority.
- R8: A strobe edge with `upset_en` low, or with `upset_idx` at or above the codeword width, changes nothing.
- R9: Flips are taken on rising edges of `upset_stb`, which may fall anywhere inside a clock period.
- R10: In the parity variant the codeword is 17 bits (bits 0 to 15 data, bit 16 even parity). A read returns the stored data bits unchanged, raises `err_uncorrectable` when an odd number of bits are flipped, never raises `err_corrected`, and ignores indices 17 and above.
- R11: Synchronous active-low reset clears `rd_valid` and both flags and stores a valid codeword for data zero.
- R12: A read and a write in the same cycle return the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Store `wr_data` with fresh check bits at the clock edge |
| wr_data | input | 16 | Data to store |
| rd_en | input | 1 | Decode the stored word at the clock edge |
| upset_stb | input | 1 | Rising edge applies one fault |
| upset_en | input | 1 | Enables the fault on the strobe edge |
| upset_idx | input | 5 | Codeword bit to invert |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_en` |
| rd_data | output | 16 | Corrected (or, in the parity variant, raw) data |
| err_corrected | output | 1 | Single error was repaired in this result |
| err_uncorrectable | output | 1 | Error detected that could not be repaired |

## Verification
The bench sweeps a single flip across every codeword bit, including check bits and the overall parity bit; a decoder with a wrong position map would return altered data or misreport a check-bit fault as uncorrectable. Double flips, same-bit cancellation and repeated reads target a design that regenerates check bits on a flip or writes corrected data back, which would show a clean word where a fault must still be reported. Flips pushed during a write, with the enable low, or at out-of-range indices catch a register that lets a discarded fault through, and a same-cycle read and write catches a read that sees the new word. A parity-variant instance shares the stimulus, so even flip counts must stay silent while odd counts raise the detect flag.

// File: rtl/seu_edac_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the protected register.
// Assumes data widths small enough that the Hamming loops stay short.
package seu_edac_pkg;

    typedef enum logic {
        PROT_SECDED = 1'b0,
        PROT_PARITY = 1'b1
    } prot_e;

    // Number of Hamming check bits needed to cover dw data bits.
    function automatic int hamming_checks(input int dw);
        int p;
        p = 0;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // Stored codeword width for a given protection scheme.
    function automatic int codeword_width(input int dw, input prot_e mode);
        if (mode == PROT_SECDED) return dw + hamming_checks(dw) + 1;
        return dw + 1;
    endfunction

    // True when v is a power of two (a check-bit position).
    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/seu_edac_enc.sv
`timescale 1ns/1ps
// Check-bit encoder: maps a data word onto a full codeword.
// SEC-DED layout: bit k is Hamming position k+1, check bits at powers of
// two, data in the remaining positions ascending, overall parity on top.
// Parity layout: data in the low bits, even parity in the top bit.
module seu_edac_enc
    import seu_edac_pkg::*;
#(
    parameter int    DW   = 16,
    parameter int    CW   = 22,
    parameter prot_e PROT = PROT_SECDED
) (
    input  logic [DW-1:0] data,
    output logic [CW-1:0] cw
);

    generate
        if (PROT == PROT_SECDED) begin : g_secded
            localparam int P  = hamming_checks(DW);
            localparam int HW = DW + P;

            logic [HW-1:0] ham;

            // Place data bits, then fill each check bit with its group parity.
            always_comb begin
                logic [HW-1:0] h;
                logic          acc;
                int            j;
                h = '0;
                j = 0;
                for (int pos = 1; pos <= HW; pos++) begin
                    if (!is_pow2(pos)) begin
                        h[pos-1] = data[j];
                        j++;
                    end
                end
                for (int k = 0; k < P; k++) begin
                    acc = 1'b0;
                    for (int pos = 1; pos <= HW; pos++) begin
                        if (((pos >> k) & 1) == 1) acc = acc ^ h[pos-1];
                    end
                    h[(1 << k) - 1] = acc;
                end
                ham = h;
            end

            assign cw = {^ham, ham};
        end else begin : g_parity
            assign cw = {^data, data};
        end
    endgenerate

endmodule

// File: rtl/seu_edac_dec.sv
`timescale 1ns/1ps
// Codeword decoder: recovers data and classifies the error pattern.
// Purely combinational; assumes the same layout as seu_edac_enc.
module seu_edac_dec
    import seu_edac_pkg::*;
#(
    parameter int    DW   = 16,
    parameter int    CW   = 22,
    parameter prot_e PROT = PROT_SECDED
) (
    input  logic [CW-1:0] cw,
    output logic [DW-1:0] data,
    output logic          corr,
    output logic          uncorr
);

    generate
        if (PROT == PROT_SECDED) begin : g_secded
            localparam int P  = hamming_checks(DW);
            localparam int HW = DW + P;

            // Form syndrome and overall parity, repair one data bit, classify.
            always_comb begin
                logic [P-1:0] syn;
                logic         ov;
                int           j;
                syn = '0;
                for (int pos = 1; pos <= HW; pos++) begin
                    if (cw[pos-1]) syn = syn ^ P'(pos);
                end
                ov   = ^cw;
                data = '0;
                j    = 0;
                for (int pos = 1; pos <= HW; pos++) begin
                    if (!is_pow2(pos)) begin
                        data[j] = cw[pos-1] ^ (ov && (syn == P'(pos)));
                        j++;
                    end
                end
                corr   = ov && (int'(syn) <= HW);
                uncorr = (!ov && (syn != '0)) || (ov && (int'(syn) > HW));
            end
        end else begin : g_parity
            // Detection only: pass data through and report odd parity.
            always_comb begin
                data   = cw[DW-1:0];
                corr   = 1'b0;
                uncorr = ^cw;
            end
        end
    endgenerate

endmodule

// File: rtl/seu_upset_mask.sv
`timescale 1ns/1ps
// Fault accumulator clocked by the upset strobe, not the functional clock.
// Each accepted edge toggles one mask bit. Assumes rst_n is held low across
// at least one strobe edge at start-up so the mask begins at zero.
module seu_upset_mask #(
    parameter int CW    = 22,
    parameter int IDX_W = 5
) (
    input  logic             upset_stb,
    input  logic             rst_n,
    input  logic             upset_en,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] upset_idx,
    output logic [CW-1:0]    mask
);

    logic [CW-1:0] hot;
    logic          accept;

    // One-hot select; indices past the codeword select nothing.
    always_comb begin
        for (int i = 0; i < CW; i++) hot[i] = (upset_idx == IDX_W'(i));
        accept = upset_en && !wr_en;
    end

    // Toggle the chosen bit on each accepted strobe edge.
    always_ff @(posedge upset_stb) begin
        if (!rst_n)      mask <= '0;
        else if (accept) mask <= mask ^ hot;
    end

    // A strobe during a write leaves the mask untouched.
    assert_flip_blocked_R7: assert property (@(posedge upset_stb) disable iff (!rst_n)
        $past(upset_en && wr_en) |-> (mask == $past(mask)));

    // A disabled strobe leaves the mask untouched.
    assert_disabled_ignored_R8: assert property (@(posedge upset_stb) disable iff (!rst_n)
        $past(!upset_en) |-> (mask == $past(mask)));

    // An accepted in-range strobe inverts exactly one bit.
    assert_single_toggle_R9: assert property (@(posedge upset_stb) disable iff (!rst_n)
        $past(upset_en && !wr_en && (int'(upset_idx) < CW))
        |-> ($countones(mask ^ $past(mask)) == 1));

endmodule

// File: rtl/seu_edac_reg.sv
`timescale 1ns/1ps
// Protected storage word with a fault-injection port behind the encoder.
// Writes store a freshly encoded codeword and snapshot the fault mask, so
// earlier faults vanish; the visible word is the stored codeword XOR the
// faults taken since that snapshot. Reads decode and register the result.
module seu_edac_reg
    import seu_edac_pkg::*;
#(
    parameter int    DW    = 16,
    parameter int    IDX_W = 5,
    parameter prot_e PROT  = PROT_SECDED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    input  logic             upset_stb,
    input  logic             upset_en,
    input  logic [IDX_W-1:0] upset_idx,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             err_corrected,
    output logic             err_uncorrectable
);

    localparam int CW = codeword_width(DW, PROT);

    logic [CW-1:0] enc_cw;
    logic [CW-1:0] cw_q;
    logic [CW-1:0] mask;
    logic [CW-1:0] ref_q;
    logic [CW-1:0] seen_cw;
    logic [DW-1:0] dec_data;
    logic          dec_corr;
    logic          dec_uncorr;

    seu_edac_enc #(.DW(DW), .CW(CW), .PROT(PROT)) i_enc (
        .data (wr_data),
        .cw   (enc_cw)
    );

    seu_upset_mask #(.CW(CW), .IDX_W(IDX_W)) i_mask (
        .upset_stb (upset_stb),
        .rst_n     (rst_n),
        .upset_en  (upset_en),
        .wr_en     (wr_en),
        .upset_idx (upset_idx),
        .mask      (mask)
    );

    // Storage word plus the fault-mask snapshot taken at the last write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw_q  <= '0;
            ref_q <= mask;
        end else if (wr_en) begin
            cw_q  <= enc_cw;
            ref_q <= mask;
        end
    end

    // Codeword as a read sees it, including faults since the last write.
    assign seen_cw = cw_q ^ mask ^ ref_q;

    seu_edac_dec #(.DW(DW), .CW(CW), .PROT(PROT)) i_dec (
        .cw     (seen_cw),
        .data   (dec_data),
        .corr   (dec_corr),
        .uncorr (dec_uncorr)
    );

    // Register the read result; flags are single-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid          <= 1'b0;
            rd_data           <= '0;
            err_corrected     <= 1'b0;
            err_uncorrectable <= 1'b0;
        end else begin
            rd_valid          <= rd_en;
            err_corrected     <= rd_en && dec_corr;
            err_uncorrectable <= rd_en && dec_uncorr;
            if (rd_en) rd_data <= dec_data;
        end
    end

    assert_read_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_flags_with_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> !(err_corrected || err_uncorrectable));

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_corrected, err_uncorrectable}));

    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |=> !(rd_valid || err_corrected || err_uncorrectable));

endmodule

// File: tb/test_seu_edac_reg.sv
`timescale 1ns/1ps
module test_seu_edac_reg;
    import seu_edac_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        upset_stb = 1'b0;
    logic        upset_en = 1'b0;
    logic [4:0]  upset_idx = '0;

    logic        s_valid, s_corr, s_unc;
    logic [15:0] s_data;
    logic        p_valid, p_corr, p_unc;
    logic [15:0] p_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seu_edac_reg #(.DW(16), .IDX_W(5), .PROT(PROT_SECDED)) i_seu_edac_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .upset_stb(upset_stb), .upset_en(upset_en), .upset_idx(upset_idx),
        .rd_valid(s_valid), .rd_data(s_data),
        .err_corrected(s_corr), .err_uncorrectable(s_unc)
    );

    seu_edac_reg #(.DW(16), .IDX_W(5), .PROT(PROT_PARITY)) i_seu_edac_reg_par (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .upset_stb(upset_stb), .upset_en(upset_en), .upset_idx(upset_idx),
        .rd_valid(p_valid), .rd_data(p_data),
        .err_corrected(p_corr), .err_uncorrectable(p_unc)
    );

    // Reference model state
    logic [15:0] m_data = '0;
    logic [21:0] m_mask_s = '0;
    logic [16:0] m_mask_p = '0;

    typedef struct {
        string       tag;
        bit          chk_s;
        bit          chk_data_s;
        logic [15:0] data_s;
        bit          corr_s;
        bit          unc_s;
        logic [15:0] data_p;
        bit          unc_p;
    } exp_t;

    exp_t q[$];

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t predict(input string tag);
        exp_t e;
        int   n;
        e.tag = tag;
        n = $countones(m_mask_s);
        e.chk_s      = (n <= 2);
        e.chk_data_s = (n <= 1);
        e.data_s     = m_data;
        e.corr_s     = (n == 1);
        e.unc_s      = (n == 2);
        e.data_p     = m_data ^ m_mask_p[15:0];
        e.unc_p      = ^m_mask_p;
        return e;
    endfunction

    // Driver tasks
    task automatic do_write(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        m_data = d; m_mask_s = '0; m_mask_p = '0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input string tag);
        @(negedge clk);
        rd_en = 1'b1;
        q.push_back(predict(tag));
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_read_write(input string tag, input logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; wr_data = d;
        q.push_back(predict(tag));
        m_data = d; m_mask_s = '0; m_mask_p = '0;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    // Strobe lands mid-cycle, well clear of the clock edge.
    task automatic do_flip(input logic [4:0] idx, input logic en);
        @(negedge clk);
        upset_en = en; upset_idx = idx;
        #1 upset_stb = 1'b1;
        #1 upset_stb = 1'b0;
        #1 upset_en = 1'b0;
        if (en) begin
            if (idx < 5'd22) m_mask_s[idx] = ~m_mask_s[idx];
            if (idx < 5'd17) m_mask_p[idx] = ~m_mask_p[idx];
        end
    endtask

    // Write with a strobe edge while wr_en is high: the flip must be dropped.
    task automatic do_write_with_flip(input logic [15:0] d, input logic [4:0] idx);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; upset_en = 1'b1; upset_idx = idx;
        #1 upset_stb = 1'b1;
        #1 upset_stb = 1'b0;
        m_data = d; m_mask_s = '0; m_mask_p = '0;
        @(negedge clk);
        wr_en = 1'b0; upset_en = 1'b0;
    endtask

    // Monitor: pop the scoreboard on every valid result.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (s_valid !== p_valid) check("R1", "valid match", {31'b0, p_valid}, {31'b0, s_valid});
            if (s_valid) begin
                if (q.size() == 0) begin
                    check("R1", "unexpected result", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.chk_s) begin
                        if (e.chk_data_s) check(e.tag, "secded data", {16'b0, s_data}, {16'b0, e.data_s});
                        check(e.tag, "secded corrected", {31'b0, s_corr}, {31'b0, e.corr_s});
                        check(e.tag, "secded uncorrectable", {31'b0, s_unc}, {31'b0, e.unc_s});
                    end
                    check({e.tag, "/R10"}, "parity data", {16'b0, p_data}, {16'b0, e.data_p});
                    check({e.tag, "/R10"}, "parity detect", {31'b0, p_unc}, {31'b0, e.unc_p});
                    check({e.tag, "/R10"}, "parity corrected", {31'b0, p_corr}, 32'd0);
                end
            end
        end
    end

    initial begin
        #1600000;
        if (!done) begin
            done = 1'b1;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // Reset, with strobe edges so the fault masks start clear.
        repeat (2) @(negedge clk);
        #1 upset_stb = 1'b1;
        #1 upset_stb = 1'b0;
        repeat (3) @(negedge clk);
        // R11: outputs quiet during reset
        check("R11", "valid in reset", {31'b0, s_valid}, 32'd0);
        check("R11", "flags in reset", {30'b0, s_corr, s_unc}, 32'd0);
        check("R11", "parity flags in reset", {30'b0, p_corr, p_unc}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "valid after reset", {31'b0, s_valid}, 32'd0);
        do_read("R11");

        // R1: plain storage
        do_write(16'hA5C3); do_read("R1");
        do_write(16'hFFFF); do_read("R1");
        do_write(16'h1234); do_read("R1");

        // R2, R9: single flip swept over every codeword bit
        for (int i = 0; i < 22; i++) begin
            do_write(16'h3C5A ^ 16'(i * 16'h0911));
            do_flip(5'(i), 1'b1);
            do_read("R2");
        end

        // R3: double flips
        do_write(16'h0F0F); do_flip(5'd3, 1'b1); do_flip(5'd10, 1'b1); do_read("R3");
        do_write(16'h8001); do_flip(5'd0, 1'b1); do_flip(5'd21, 1'b1); do_read("R3");
        do_write(16'h7777); do_flip(5'd16, 1'b1); do_flip(5'd15, 1'b1); do_read("R3");

        // R4: no write-back on read
        do_write(16'hBEEF); do_flip(5'd5, 1'b1);
        do_read("R4"); do_read("R4");

        // R5: write discards accumulated faults
        do_flip(5'd7, 1'b1); do_flip(5'd12, 1'b1); do_read("R5");
        do_write(16'h4321); do_read("R5");

        // R6: same bit twice cancels
        do_flip(5'd4, 1'b1); do_flip(5'd4, 1'b1); do_read("R6");

        // R7: write takes priority over a coincident flip
        do_write_with_flip(16'hC001, 5'd9); do_read("R7");

        // R8: disabled strobe and out-of-range index ignored
        do_flip(5'd3, 1'b0); do_read("R8");
        do_flip(5'd25, 1'b1); do_read("R8");
        do_flip(5'd31, 1'b1); do_read("R8");

        // R10: index beyond the parity word only affects SEC-DED instance
        do_write(16'h5A5A); do_flip(5'd19, 1'b1); do_read("R10");

        // R12: simultaneous read and write return the old contents
        do_write(16'h1111); do_read_write("R12", 16'h2222); do_read("R12");

        repeat (4) @(negedge clk);
        check("R1", "scoreboard drained", q.size(), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule